// File: doc/BRIEF.md
# Slotted Channel-to-Memory Word Port

This block sits between four groups of six serial channels (one group per I/O controller) and one shared memory write port. Every channel delivers 16-bit parcels, each with three control bits and four check bits. For each channel the block checks the parcel's parity, sets a sticky error flag on a mismatch, and packs four parcels into one 64-bit word.

The memory port is shared by fixed time slots, not by requests. A slot counter steps through the controllers in turn, one per clock. In its slot, a controller may write one pending word. Its channels take turns round-robin. A slot whose controller has nothing pending goes unused. When a word is written, the block also produces check bits for the whole word, one even-parity bit per nibble.

Top module: `io_slot_port`

## Requirements
- R1: While reset is active and on the first cycle after it, `mem_we_o` is 0 and every bit of `err_o` is 0.
- R2: The slot counter is 0 on the first rising edge after reset and advances by one on every edge, modulo 4. A write granted at edge k (counting from 0) is visible on `mem_we_o` after that edge. It belongs to the controller numbered k mod 4, and `mem_chan_o` / 6 equals that number.
- R3: Each channel packs its parcels most significant first. The first parcel goes to bits 63:48 and the fourth to bits 15:0. The word becomes pending at the edge that samples the fourth parcel.
- R4: A parcel with control bit 0 set restarts packing. That parcel becomes the first parcel of a new word, and any partial word is discarded. Control bits 2:1 have no effect.
- R5: Check bit i of a parcel must equal the XOR of data bits 4i+3..4i. On a mismatch, `err_o[ch]` is set at the edge that samples the parcel and stays set until reset. The parcel is still packed.
- R6: On every write, `mem_chk_o[j]` equals the XOR of `mem_data_o[4j+3:4j]`.
- R7: Within a controller's slot, the pending channels are served round-robin. The search starts at the channel after the one served last by that controller, and after reset it starts at local channel 0.
- R8: A slot whose controller has no pending word produces no write, and it is not given to another controller.
- R9: A channel holds at most one pending word. If a new word completes while the held word is neither being written at that edge nor written earlier, the new word is discarded and the held word is later written unchanged.
- R10: `mem_chan_o` equals controller*6 + local channel index and is below 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_valid_i | input | 24 | Parcel strobe, one bit per channel |
| par_data_i | input | 384 | Parcel data, 16 bits per channel, channel 0 in the low bits |
| par_ctrl_i | input | 72 | Control bits, 3 per channel; bit 0 restarts packing |
| par_chk_i | input | 96 | Parcel check bits, 4 per channel |
| mem_we_o | output | 1 | Memory write strobe |
| mem_chan_o | output | 5 | Global index of the source channel |
| mem_data_o | output | 64 | Packed word |
| mem_chk_o | output | 16 | Nibble parity of the packed word |
| err_o | output | 24 | Sticky parity error flag, one bit per channel |

## Verification
The error flag and the pending state of a channel change at the edge that samples the parcel. A pending word can be granted no earlier than the next edge whose slot number matches its controller. The write then appears on the outputs during the cycle after that grant edge. The bench drives inputs at the falling edge and steps a model from the requirements once per rising edge. It compares strobe, channel, word, check bits and error flags at the next falling edge, so every result is sampled in the cycle it is due.

// File: rtl/io_slot_pkg.sv
package io_slot_pkg;
  localparam int unsigned PARCEL_W = 16;
  localparam int unsigned CHK_W    = PARCEL_W / 4;
  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned SYNC_BIT = 0;

  typedef struct packed {
    logic [CTRL_W-1:0]   ctrl;
    logic [PARCEL_W-1:0] data;
    logic [CHK_W-1:0]    chk;
  } parcel_t;

  function automatic logic [CHK_W-1:0] nib_par(input logic [PARCEL_W-1:0] d);
    logic [CHK_W-1:0] p;
    for (int j = 0; j < CHK_W; j++) p[j] = ^d[4*j +: 4];
    return p;
  endfunction
endpackage

// File: rtl/io_chan_pack.sv
module io_chan_pack
  import io_slot_pkg::*;
#(
  parameter int unsigned PARCELS = 4,
  localparam int unsigned WORD_W = PARCELS * PARCEL_W,
  localparam int unsigned ACC_W  = (PARCELS - 1) * PARCEL_W,
  localparam int unsigned CNT_W  = $clog2(PARCELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  parcel_t           parcel_i,
  input  logic              grant_i,
  output logic              pend_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] buf_q;
  logic              buf_v_q, err_q;
  logic              sync, last, bad;
  logic              unused_ctrl;

  assign unused_ctrl = ^parcel_i.ctrl;
  assign sync = parcel_i.ctrl[SYNC_BIT];
  assign last = valid_i && !sync && (cnt_q == CNT_W'(PARCELS - 1));
  assign bad  = valid_i && (nib_par(parcel_i.data) != parcel_i.chk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      buf_q   <= '0;
      buf_v_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (valid_i) begin
        if (sync) begin
          acc_q <= ACC_W'(parcel_i.data);
          cnt_q <= CNT_W'(1);
        end else if (last) begin
          cnt_q <= '0;
        end else begin
          acc_q <= ACC_W'({acc_q, parcel_i.data});
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // a completed word only lands if the holding register is free this edge
      if (last && (!buf_v_q || grant_i)) begin
        buf_q   <= {acc_q, parcel_i.data};
        buf_v_q <= 1'b1;
      end else if (grant_i) begin
        buf_v_q <= 1'b0;
      end
      if (bad) err_q <= 1'b1;
    end
  end

  assign pend_o = buf_v_q;
  assign word_o = buf_q;
  assign err_o  = err_q;
endmodule

// File: rtl/io_ctrl_pick.sv
module io_ctrl_pick #(
  parameter int unsigned N_CHAN = 6,
  localparam int unsigned IDX_W = $clog2(N_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_en_i,
  input  logic [N_CHAN-1:0] pend_i,
  output logic [N_CHAN-1:0] gnt_o
);
  logic [IDX_W-1:0] last_q, idx;
  logic             found;

  always_comb begin
    gnt_o = '0;
    idx   = last_q;
    found = 1'b0;
    for (int i = 1; i <= N_CHAN; i++) begin
      int c;
      c = (int'(last_q) + i) % N_CHAN;
      if (slot_en_i && pend_i[c] && !found) begin
        gnt_o[c] = 1'b1;
        idx      = IDX_W'(c);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IDX_W'(N_CHAN - 1);
    else if (found) last_q <= idx;
  end
endmodule

// File: rtl/io_slot_port.sv
module io_slot_port
  import io_slot_pkg::*;
#(
  parameter int unsigned N_CTRL  = 4,
  parameter int unsigned N_CHAN  = 6,
  parameter int unsigned PARCELS = 4,
  localparam int unsigned NCH    = N_CTRL * N_CHAN,
  localparam int unsigned WORD_W = PARCELS * PARCEL_W,
  localparam int unsigned WCHK_W = WORD_W / 4,
  localparam int unsigned CH_W   = $clog2(NCH),
  localparam int unsigned SLOT_W = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NCH-1:0]           par_valid_i,
  input  logic [NCH*PARCEL_W-1:0]  par_data_i,
  input  logic [NCH*CTRL_W-1:0]    par_ctrl_i,
  input  logic [NCH*CHK_W-1:0]     par_chk_i,
  output logic                     mem_we_o,
  output logic [CH_W-1:0]          mem_chan_o,
  output logic [WORD_W-1:0]        mem_data_o,
  output logic [WCHK_W-1:0]        mem_chk_o,
  output logic [NCH-1:0]           err_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [NCH-1:0]    pend, gnt_all;
  logic [WORD_W-1:0] word_arr [NCH];
  logic [WORD_W-1:0] sel_word;
  logic [CH_W-1:0]   sel_chan;
  logic [WCHK_W-1:0] sel_chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else slot_q <= (slot_q == SLOT_W'(N_CTRL - 1)) ? '0 : slot_q + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    parcel_t pc;
    assign pc.ctrl = par_ctrl_i[g*CTRL_W +: CTRL_W];
    assign pc.data = par_data_i[g*PARCEL_W +: PARCEL_W];
    assign pc.chk  = par_chk_i[g*CHK_W +: CHK_W];
    io_chan_pack #(.PARCELS(PARCELS)) u_pack (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (par_valid_i[g]),
      .parcel_i (pc),
      .grant_i  (gnt_all[g]),
      .pend_o   (pend[g]),
      .word_o   (word_arr[g]),
      .err_o    (err_o[g])
    );
  end

  for (genvar c = 0; c < N_CTRL; c++) begin : g_ctrl
    io_ctrl_pick #(.N_CHAN(N_CHAN)) u_pick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .slot_en_i (slot_q == SLOT_W'(c)),
      .pend_i    (pend[c*N_CHAN +: N_CHAN]),
      .gnt_o     (gnt_all[c*N_CHAN +: N_CHAN])
    );
  end

  always_comb begin
    sel_word = '0;
    sel_chan = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt_all[i]) begin
        sel_word = sel_word | word_arr[i];
        sel_chan = CH_W'(i);
      end
    end
    for (int j = 0; j < WCHK_W; j++) sel_chk[j] = ^sel_word[4*j +: 4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_chan_o <= '0;
      mem_data_o <= '0;
      mem_chk_o  <= '0;
    end else begin
      mem_we_o <= |gnt_all;
      if (|gnt_all) begin
        mem_chan_o <= sel_chan;
        mem_data_o <= sel_word;
        mem_chk_o  <= sel_chk;
      end
    end
  end
endmodule

// File: rtl/io_slot_port_chk.sv
module io_slot_port_chk #(
  parameter int unsigned N_CTRL  = 4,
  parameter int unsigned N_CHAN  = 6,
  parameter int unsigned PARCELS = 4,
  localparam int unsigned NCH    = N_CTRL * N_CHAN,
  localparam int unsigned WORD_W = PARCELS * 16,
  localparam int unsigned WCHK_W = WORD_W / 4,
  localparam int unsigned CH_W   = $clog2(NCH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_we_i,
  input logic [CH_W-1:0]   mem_chan_i,
  input logic [WORD_W-1:0] mem_data_i,
  input logic [WCHK_W-1:0] mem_chk_i,
  input logic [NCH-1:0]    err_i,
  input logic [NCH-1:0]    gnt_i
);
  int unsigned ph_q;
  int unsigned owner;
  logic [WCHK_W-1:0] data_par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 0;
    else ph_q <= (ph_q + 1) % N_CTRL;
  end

  always_comb begin
    owner = (ph_q + N_CTRL - 1) % N_CTRL;
    for (int j = 0; j < WCHK_W; j++) data_par[j] = ^mem_data_i[4*j +: 4];
  end

  assert_slot_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (int'(mem_chan_i) / N_CHAN) == int'(owner));

  assert_word_chk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> mem_chk_i == data_par);

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i & $past(err_i)) == $past(err_i));

  assert_one_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  assert_chan_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> int'(mem_chan_i) < NCH);

  assert_slot_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i || (int'(mem_chan_i) / N_CHAN) != (int'($past(mem_chan_i)) / N_CHAN));
endmodule

bind io_slot_port io_slot_port_chk #(
  .N_CTRL(N_CTRL), .N_CHAN(N_CHAN), .PARCELS(PARCELS)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_we_i   (mem_we_o),
  .mem_chan_i (mem_chan_o),
  .mem_data_i (mem_data_o),
  .mem_chk_i  (mem_chk_o),
  .err_i      (err_o),
  .gnt_i      (gnt_all)
);

// File: tb/io_slot_port_tb_top.sv
`timescale 1ns/1ps
module io_slot_port_tb_top;
  localparam int NC = 4, NL = 6, NCH = 24;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] par_valid_i = '0;
  logic [NCH*16-1:0] par_data_i = '0;
  logic [NCH*3-1:0]  par_ctrl_i = '0;
  logic [NCH*4-1:0]  par_chk_i = '0;
  logic           mem_we_o;
  logic [4:0]     mem_chan_o;
  logic [63:0]    mem_data_o;
  logic [15:0]    mem_chk_o;
  logic [NCH-1:0] err_o;

  io_slot_port dut_i (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // reference state
  int          m_cnt [NCH];
  logic [47:0] m_acc [NCH];
  logic [63:0] m_buf [NCH];
  bit          m_bv  [NCH];
  int          m_last[NC];
  logic [NCH-1:0] m_err;
  int          m_k;
  bit          e_we;
  int          e_chan;
  logic [63:0] e_data;

  function automatic logic [3:0] npar(input logic [15:0] d);
    for (int j = 0; j < 4; j++) npar[j] = ^d[4*j +: 4];
  endfunction

  function automatic logic [15:0] wpar(input logic [63:0] w);
    for (int j = 0; j < 16; j++) wpar[j] = ^w[4*j +: 4];
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual=%h expected=%h", req, tag, what, act, exp);
    end
  endtask

  task automatic put(input int ch, input logic [15:0] d, input logic [2:0] c, input bit bad);
    par_valid_i[ch] = 1'b1;
    par_data_i[ch*16 +: 16] = d;
    par_ctrl_i[ch*3 +: 3] = c;
    par_chk_i[ch*4 +: 4] = npar(d) ^ (bad ? 4'b0100 : 4'b0000);
  endtask

  task automatic clear_in();
    par_valid_i = '0;
  endtask

  task automatic model_step();
    int ph, gsel;
    bit g [NCH];
    ph = m_k % NC;
    gsel = -1;
    for (int i = 0; i < NCH; i++) g[i] = 0;
    for (int i = 1; i <= NL; i++) begin
      int c;
      c = (m_last[ph] + i) % NL;
      if (gsel < 0 && m_bv[ph*NL + c]) gsel = c;
    end
    e_we = (gsel >= 0);
    if (e_we) begin
      e_chan = ph*NL + gsel;
      e_data = m_buf[e_chan];
      g[e_chan] = 1;
      m_last[ph] = gsel;
    end
    for (int ch = 0; ch < NCH; ch++) begin
      logic [15:0] d;
      bit comp;
      d = par_data_i[ch*16 +: 16];
      comp = 0;
      if (par_valid_i[ch]) begin
        if (npar(d) != par_chk_i[ch*4 +: 4]) m_err[ch] = 1'b1;
        if (par_ctrl_i[ch*3]) begin
          m_acc[ch] = {32'h0, d};
          m_cnt[ch] = 1;
        end else if (m_cnt[ch] == 3) begin
          comp = 1;
          m_cnt[ch] = 0;
        end else begin
          m_acc[ch] = {m_acc[ch][31:0], d};
          m_cnt[ch]++;
        end
      end
      if (comp && (!m_bv[ch] || g[ch])) begin
        m_buf[ch] = {m_acc[ch], d};
        m_bv[ch] = 1;
      end else if (g[ch]) m_bv[ch] = 0;
    end
    m_k++;
  endtask

  task automatic check_out();
    cmp("R2", "mem_we_o", {63'h0, mem_we_o}, {63'h0, e_we});
    if (e_we && mem_we_o) begin
      cmp("R10", "mem_chan_o (R7 order)", {59'h0, mem_chan_o}, 64'(e_chan));
      cmp("R3", "mem_data_o", mem_data_o, e_data);
      cmp("R6", "mem_chk_o", {48'h0, mem_chk_o}, {48'h0, wpar(mem_data_o)});
    end
    cmp("R5", "err_o", {40'h0, err_o}, {40'h0, m_err});
  endtask

  task automatic step();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
    check_out();
  endtask

  task automatic idle(input int n);
    clear_in();
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rand_in(input int pct, input int lo, input int hi);
    clear_in();
    for (int ch = lo; ch <= hi; ch++) begin
      if (($urandom % 100) < pct) begin
        logic [2:0] c;
        c = 3'($urandom) & 3'b110;
        if (($urandom % 100) < 4) c[0] = 1'b1;
        put(ch, 16'($urandom), c, ($urandom % 100) < 2);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin
      m_cnt[i] = 0; m_acc[i] = '0; m_buf[i] = '0; m_bv[i] = 0;
    end
    for (int i = 0; i < NC; i++) m_last[i] = NL - 1;
    m_err = '0; m_k = 0; e_we = 0; e_chan = 0; e_data = '0;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    cmp("R1", "mem_we_o in reset", {63'h0, mem_we_o}, 64'h0);
    cmp("R1", "err_o in reset", {40'h0, err_o}, 64'h0);
    rst_ni = 1'b1;
    tag = "R1";
    idle(1);
    cmp("R1", "mem_we_o after reset", {63'h0, mem_we_o}, 64'h0);

    // R3: one word on channel 7, MSB parcel first
    tag = "R3";
    put(7, 16'hA1B2, 3'b000, 0); step(); clear_in();
    put(7, 16'hC3D4, 3'b000, 0); step(); clear_in();
    put(7, 16'hE5F6, 3'b000, 0); step(); clear_in();
    put(7, 16'h0718, 3'b000, 0); step();
    idle(8);

    // R4: restart mid-word, upper control bits set
    tag = "R4";
    put(0, 16'h1111, 3'b110, 0); step(); clear_in();
    put(0, 16'h2222, 3'b010, 0); step(); clear_in();
    put(0, 16'h3333, 3'b001, 0); step(); clear_in();
    put(0, 16'h4444, 3'b100, 0); step(); clear_in();
    put(0, 16'h5555, 3'b110, 0); step(); clear_in();
    put(0, 16'h6666, 3'b000, 0); step();
    idle(8);

    // R5: bad check bits on channel 13, flag stays set
    tag = "R5";
    put(13, 16'hBEEF, 3'b000, 1); step();
    idle(6);

    // R8: only controller 0 has traffic
    tag = "R8";
    for (int i = 0; i < 40; i++) begin
      clear_in(); put(2, 16'($urandom), 3'b000, 0); step();
    end
    idle(10);

    // R7: all channels of controller 2 complete together
    tag = "R7";
    for (int p = 0; p < 4; p++) begin
      clear_in();
      for (int ch = 12; ch < 18; ch++) put(ch, 16'(ch*256 + p), 3'b000, 0);
      step();
    end
    idle(30);

    // R9: controller 3 saturated, words are dropped
    tag = "R9";
    for (int i = 0; i < 60; i++) begin
      clear_in();
      for (int ch = 18; ch < 24; ch++) put(ch, 16'($urandom), 3'b000, 0);
      step();
    end
    idle(30);

    // mixed random traffic
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      rand_in((i < 1500) ? 15 : 60, 0, NCH - 1);
      step();
    end
    idle(40);
    finish_run();
  end
endmodule